// File: doc/BRIEF.md
# Translation Table Entry Pointer Generator

After a translation miss, software or a hardware refill engine needs the address of the entry in a memory-resident translation table. The lookup starts from the faulting virtual address. This block computes that address. Its inputs are the captured tag-access word (virtual page plus context number), a single legacy table register, four per-context table base registers and two context configuration words. A mode flag selects the rule that applies. A one-bit page-size index asks for either the primary (index 0) or the secondary (index 1) page-size pointer.

In legacy mode the block always uses the single table register, and the page-size code is the index itself: code 0 for 8 KiB pages and code 1 for 64 KiB pages. In hypervisor mode the context number picks a bank. Context zero uses the zero-context configuration word and base registers 0 and 1. Any nonzero context uses the nonzero-context configuration word and base registers 2 and 3. The page-size code comes from a 3-bit field of the chosen configuration word. The virtual address is shifted into place according to that code. The table size field then decides how many of the low pointer bits come from the address and how many come from the base. A split table adds one more address bit, which steers the two page sizes into separate halves.

The `REGISTERED` parameter selects the output stage. When it is 1, the pointer is captured on a request strobe and shown with a valid flag in the following cycle. When it is 0, the pointer is combinational and the valid flag follows the strobe.

Top module: `tsb_ptr_gen`

## Requirements
- R1: In hypervisor mode, a context number (tag-access bits [12:0]) of zero selects the zero-context configuration word and base registers 0/1. A nonzero context selects the nonzero-context configuration word and base registers 2/3.
- R2: In hypervisor mode, the base register number is {context_nonzero, page_index}, so base register 3 serves a nonzero context with index 1.
- R3: In hypervisor mode, the page-size code is configuration bits [2:0] for index 0 and bits [10:8] for index 1. All other configuration bits have no effect on the pointer.
- R4: In legacy mode, the legacy table register is used and the page-size code equals the index. The four base registers and both configuration words then have no effect on the pointer.
- R5: The tag-access word with bits [12:0] cleared is shifted right by 3*code+9 bits to form the address part of the pointer.
- R6: With table size s = register bits [3:0], pointer bits [12+s:0] come from the shifted address. The bits above come from the selected register, whose bits [12:0] are treated as zero.
- R7: When register bit 12 (split) is set, the address region widens by one bit to [13+s:0]. Pointer bit 13+s is forced to the page index: 0 for index 0 and 1 for index 1.
- R8: Pointer bits [3:0] are always zero, giving 16-byte entry alignment.
- R9: With REGISTERED=1, ptr_valid is high exactly in the cycle after a cycle in which req was high. entry_ptr holds the value captured at the last request until the next one.
- R10: After reset, ptr_valid is 0 and entry_ptr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Compute strobe; inputs are sampled on this cycle's rising edge |
| hyp_mode | input | 1 | 1 selects per-context registers, 0 selects the legacy rule |
| pg_idx | input | 1 | Page-size index: 0 primary, 1 secondary |
| tag_access | input | 64 | Faulting virtual page with context number in bits [12:0] |
| legacy_tsb | input | 64 | Legacy table register |
| tsb_base0 | input | 64 | Context-zero base, index 0 |
| tsb_base1 | input | 64 | Context-zero base, index 1 |
| tsb_base2 | input | 64 | Nonzero-context base, index 0 |
| tsb_base3 | input | 64 | Nonzero-context base, index 1 |
| ctx_cfg_zero | input | 64 | Zero-context page-size configuration |
| ctx_cfg_nonzero | input | 64 | Nonzero-context page-size configuration |
| ptr_valid | output | 1 | Pointer is valid for the preceding request |
| entry_ptr | output | 64 | Computed table entry pointer |

## Verification
Directed patterns come first. Legacy requests carry garbage in the unused registers, which separates the legacy path from the per-context path. Context values of zero, one and all ones are each paired with four distinct bases, which separates bank choice from index choice. Configuration words hold different codes in the two fields and junk elsewhere, which exposes a swapped or widened field. Page-size codes 0 to 7 and table sizes 0 to 15 are swept with and without split, which separates shift amounts, mask widths and the forced split bit. Idle cycles between requests confirm that the pointer is held. A long stretch of random requests then covers all combinations against a behavioural model.

// File: rtl/tsb_ptr_pkg.sv
package tsb_ptr_pkg;
   localparam int CTX_BITS   = 13;   // context number / page offset field
   localparam int SIZE_BITS  = 4;    // table size field
   localparam int CODE_BITS  = 3;    // page-size code
   localparam int SPLIT_POS  = 12;   // split flag position
   localparam int CODE1_LSB  = 8;    // secondary code field
   localparam int SHIFT_BITS = 6;    // enough for 3*7+9
   localparam int NUM_BASES  = 4;

   typedef logic [CODE_BITS-1:0] pg_code_t;
   typedef logic [SIZE_BITS-1:0] tsize_t;

   typedef struct packed {
      logic     split;
      tsize_t   size;
      pg_code_t code;
      logic     idx;
   } sel_info_t;
endpackage

// File: rtl/tsb_ptr_select.sv
module tsb_ptr_select
   import tsb_ptr_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic                          hyp_mode,
   input  logic                          pg_idx,
   input  logic [ADDR_W-1:0]             tag_access,
   input  logic [ADDR_W-1:0]             legacy_tsb,
   input  logic [NUM_BASES-1:0][ADDR_W-1:0] bases,
   input  logic [ADDR_W-1:0]             cfg_zero,
   input  logic [ADDR_W-1:0]             cfg_nonzero,
   output logic [ADDR_W-1:0]             sel_reg,
   output sel_info_t                     sel_info
);
   localparam int BANK_W = $clog2(NUM_BASES);

   logic                  ctx_nz;
   logic [BANK_W-1:0]     bank_sel;
   logic [ADDR_W-1:0]     cfg_word;
   logic [ADDR_W-1:0]     hyp_reg;
   pg_code_t              hyp_code;
   logic [NUM_BASES-1:0]  bank_hit;
   logic [NUM_BASES-1:0][ADDR_W-1:0] bank_term;

   assign ctx_nz   = |tag_access[CTX_BITS-1:0];
   assign bank_sel = {ctx_nz, pg_idx};
   assign cfg_word = ctx_nz ? cfg_nonzero : cfg_zero;

   // one-hot AND-OR mux over the base bank
   generate
      for (genvar b = 0; b < NUM_BASES; b++) begin : g_bank
         assign bank_hit[b]  = (bank_sel == BANK_W'(b));
         assign bank_term[b] = bases[b] & {ADDR_W{bank_hit[b]}};
      end
   endgenerate

   always_comb begin
      hyp_reg = '0;
      for (int b = 0; b < NUM_BASES; b++) hyp_reg |= bank_term[b];
   end

   assign hyp_code = pg_idx ? cfg_word[CODE1_LSB +: CODE_BITS]
                            : cfg_word[CODE_BITS-1:0];

   always_comb begin
      if (hyp_mode) begin
         sel_reg       = hyp_reg;
         sel_info.code = hyp_code;
      end else begin
         sel_reg       = legacy_tsb;
         sel_info.code = pg_code_t'(pg_idx);
      end
      sel_info.idx   = pg_idx;
      sel_info.split = sel_reg[SPLIT_POS];
      sel_info.size  = sel_reg[SIZE_BITS-1:0];
   end
endmodule

// File: rtl/tsb_ptr_compose.sv
module tsb_ptr_compose
   import tsb_ptr_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic [ADDR_W-1:0] tag_access,
   input  logic [ADDR_W-1:0] sel_reg,
   input  sel_info_t         sel_info,
   output logic [ADDR_W-1:0] ptr
);
   localparam logic [ADDR_W-1:0] HIGH_ONES = {{(ADDR_W-CTX_BITS){1'b1}}, {CTX_BITS{1'b0}}};
   localparam logic [ADDR_W-1:0] ALIGN_CLR = {{(ADDR_W-4){1'b1}}, 4'b0000};

   logic [SHIFT_BITS-1:0] shamt;
   logic [SHIFT_BITS-1:0] split_bit;
   logic [ADDR_W-1:0]     tbl_base;
   logic [ADDR_W-1:0]     va_page;
   logic [ADDR_W-1:0]     va_shift;
   logic [ADDR_W-1:0]     va_adj;
   logic [ADDR_W-1:0]     split_one;
   logic [ADDR_W-1:0]     size_mask;
   logic [ADDR_W-1:0]     mask;

   assign shamt     = SHIFT_BITS'(sel_info.code) * SHIFT_BITS'(3) + SHIFT_BITS'(9);
   assign split_bit = SHIFT_BITS'(CTX_BITS) + SHIFT_BITS'(sel_info.size);
   assign tbl_base  = sel_reg & HIGH_ONES;
   assign va_page   = tag_access & HIGH_ONES;
   assign va_shift  = va_page >> shamt;
   assign split_one = ADDR_W'(1) << split_bit;
   assign size_mask = HIGH_ONES << sel_info.size;

   always_comb begin
      if (sel_info.split) begin
         va_adj = sel_info.idx ? (va_shift | split_one) : (va_shift & ~split_one);
         mask   = size_mask << 1;
      end else begin
         va_adj = va_shift;
         mask   = size_mask;
      end
   end

   assign ptr = ((tbl_base & mask) | (va_adj & ~mask)) & ALIGN_CLR;
endmodule

// File: rtl/tsb_ptr_outstage.sv
module tsb_ptr_outstage #(
   parameter int ADDR_W     = 64,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [ADDR_W-1:0] ptr_in,
   output logic              ptr_valid,
   output logic [ADDR_W-1:0] ptr_out
);
   generate
      if (REGISTERED) begin : g_reg
         logic              vld_q;
         logic [ADDR_W-1:0] ptr_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               ptr_q <= '0;
            end else begin
               vld_q <= req;
               if (req) ptr_q <= ptr_in;
            end
         end
         assign ptr_valid = vld_q;
         assign ptr_out   = ptr_q;

         assert_valid_follows_req_R9: assert property (
            @(posedge clk) disable iff (!rst_n) req |=> ptr_valid);
         assert_valid_needs_req_R9: assert property (
            @(posedge clk) disable iff (!rst_n) !req |=> !ptr_valid);
         assert_ptr_held_R9: assert property (
            @(posedge clk) disable iff (!rst_n) !req |=> $stable(ptr_out));
      end else begin : g_comb
         assign ptr_valid = req;
         assign ptr_out   = ptr_in;
      end
   endgenerate

   assert_align_R8: assert property (
      @(posedge clk) disable iff (!rst_n) ptr_out[3:0] == 4'b0000);
endmodule

// File: rtl/tsb_ptr_gen.sv
module tsb_ptr_gen
   import tsb_ptr_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter bit REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              hyp_mode,
   input  logic              pg_idx,
   input  logic [ADDR_W-1:0] tag_access,
   input  logic [ADDR_W-1:0] legacy_tsb,
   input  logic [ADDR_W-1:0] tsb_base0,
   input  logic [ADDR_W-1:0] tsb_base1,
   input  logic [ADDR_W-1:0] tsb_base2,
   input  logic [ADDR_W-1:0] tsb_base3,
   input  logic [ADDR_W-1:0] ctx_cfg_zero,
   input  logic [ADDR_W-1:0] ctx_cfg_nonzero,
   output logic              ptr_valid,
   output logic [ADDR_W-1:0] entry_ptr
);
   // widest region: 13 + 15 + 1 split bit, and a shift of up to 30
   localparam int MIN_W = CTX_BITS + (1 << SIZE_BITS) + 1 + 3 * ((1 << CODE_BITS) - 1);

   generate
      if (ADDR_W < MIN_W) begin : g_bad_width
         $error("tsb_ptr_gen: ADDR_W too small for the field layout");
      end
   endgenerate

   logic [NUM_BASES-1:0][ADDR_W-1:0] bases;
   logic [ADDR_W-1:0]                sel_reg;
   sel_info_t                        sel_info;
   logic [ADDR_W-1:0]                comb_ptr;

   assign bases = {tsb_base3, tsb_base2, tsb_base1, tsb_base0};

   tsb_ptr_select #(.ADDR_W(ADDR_W)) u_select (
      .hyp_mode    (hyp_mode),
      .pg_idx      (pg_idx),
      .tag_access  (tag_access),
      .legacy_tsb  (legacy_tsb),
      .bases       (bases),
      .cfg_zero    (ctx_cfg_zero),
      .cfg_nonzero (ctx_cfg_nonzero),
      .sel_reg     (sel_reg),
      .sel_info    (sel_info)
   );

   tsb_ptr_compose #(.ADDR_W(ADDR_W)) u_compose (
      .tag_access (tag_access),
      .sel_reg    (sel_reg),
      .sel_info   (sel_info),
      .ptr        (comb_ptr)
   );

   tsb_ptr_outstage #(.ADDR_W(ADDR_W), .REGISTERED(REGISTERED)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .ptr_in    (comb_ptr),
      .ptr_valid (ptr_valid),
      .ptr_out   (entry_ptr)
   );

   // selector output vs ports: legacy mode takes the legacy register
   assert_legacy_reg_R4: assert property (
      @(posedge clk) disable iff (!rst_n) (req && !hyp_mode) |-> (sel_reg == legacy_tsb));
   // split forces the bit just above the widened size region to the index
   assert_split_bit_R7: assert property (
      @(posedge clk) disable iff (!rst_n)
      (req && sel_info.split) |-> (comb_ptr[CTX_BITS + int'(sel_info.size)] == pg_idx));
   // nonzero context in hypervisor mode never draws on the zero-context bank
   assert_ctx_bank_R1: assert property (
      @(posedge clk) disable iff (!rst_n)
      (req && hyp_mode && (tag_access[CTX_BITS-1:0] != '0)) |->
      (sel_reg == (pg_idx ? tsb_base3 : tsb_base2)));
endmodule

// File: tb/tsb_ptr_gen_tb_top.sv
module tsb_ptr_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic        hyp_mode = 1'b0;
   logic        pg_idx = 1'b0;
   logic [63:0] tag_access = '0, legacy_tsb = '0;
   logic [63:0] tsb_base0 = '0, tsb_base1 = '0, tsb_base2 = '0, tsb_base3 = '0;
   logic [63:0] ctx_cfg_zero = '0, ctx_cfg_nonzero = '0;
   logic        ptr_valid;
   logic [63:0] entry_ptr;

   always #2 clk = ~clk;   // 250 MHz

   tsb_ptr_gen dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .hyp_mode(hyp_mode), .pg_idx(pg_idx),
      .tag_access(tag_access), .legacy_tsb(legacy_tsb),
      .tsb_base0(tsb_base0), .tsb_base1(tsb_base1), .tsb_base2(tsb_base2), .tsb_base3(tsb_base3),
      .ctx_cfg_zero(ctx_cfg_zero), .ctx_cfg_nonzero(ctx_cfg_nonzero),
      .ptr_valid(ptr_valid), .entry_ptr(entry_ptr));

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    finished = 1'b0;

   // staged next inputs
   logic        n_req, n_hyp, n_idx;
   logic [63:0] n_tag, n_leg, n_cz, n_cn;
   logic [63:0] n_b [4];

   // model state
   logic        exp_valid = 1'b0;
   logic [63:0] exp_ptr   = '0;
   string       exp_tag   = "R10";

   function automatic logic [63:0] model(input logic hyp, input logic idx, input logic [63:0] tag,
                                         input logic [63:0] leg, input logic [63:0] b0,
                                         input logic [63:0] b1, input logic [63:0] b2,
                                         input logic [63:0] b3, input logic [63:0] cz,
                                         input logic [63:0] cn);
      logic [63:0] r, cfg, va, keep_lo, res;
      int code, lo_bits;
      bit nz;
      nz = (tag % 64'd8192) != 0;
      if (hyp) begin
         case ({nz, idx})
            2'd0: r = b0;
            2'd1: r = b1;
            2'd2: r = b2;
            default: r = b3;
         endcase
         cfg  = nz ? cn : cz;
         code = idx ? int'((cfg / 256) % 8) : int'(cfg % 8);
      end else begin
         r = leg;
         code = int'(idx);
      end
      va = (tag / 64'd8192) * 64'd8192;
      for (int k = 0; k < 3 * code + 9; k++) va = va / 2;
      lo_bits = 13 + int'(r % 16);
      if (r[12]) begin
         va[lo_bits] = idx;
         lo_bits = lo_bits + 1;
      end
      keep_lo = 64'd0;
      for (int k = 0; k < lo_bits; k++) keep_lo[k] = 1'b1;
      res = ((r / 64'd8192) * 64'd8192 & ~keep_lo) | (va & keep_lo);
      res = (res / 16) * 16;
      return res;
   endfunction

   task automatic check(input string rt);
      n_checks++;
      if (ptr_valid !== exp_valid || entry_ptr !== exp_ptr) begin
         n_fail++;
         $display("FAIL %s: valid=%0b ptr=%h expected valid=%0b ptr=%h",
                  rt, ptr_valid, entry_ptr, exp_valid, exp_ptr);
      end
   endtask

   // one clock: check last result, then apply staged inputs
   task automatic cyc(input string rt);
      @(negedge clk);
      check(exp_tag);
      req = n_req; hyp_mode = n_hyp; pg_idx = n_idx; tag_access = n_tag;
      legacy_tsb = n_leg; tsb_base0 = n_b[0]; tsb_base1 = n_b[1];
      tsb_base2 = n_b[2]; tsb_base3 = n_b[3];
      ctx_cfg_zero = n_cz; ctx_cfg_nonzero = n_cn;
      exp_valid = n_req;
      if (n_req) exp_ptr = model(n_hyp, n_idx, n_tag, n_leg, n_b[0], n_b[1], n_b[2], n_b[3], n_cz, n_cn);
      exp_tag = rt;
   endtask

   function automatic logic [63:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic randomize_all();
      n_tag = rnd64(); n_leg = rnd64(); n_cz = rnd64(); n_cn = rnd64();
      for (int k = 0; k < 4; k++) n_b[k] = rnd64();
   endtask

   task automatic fire(input logic hyp, input logic idx, input string rt);
      n_req = 1'b1; n_hyp = hyp; n_idx = idx;
      cyc(rt);
   endtask

   initial begin
      n_req = 0; n_hyp = 0; n_idx = 0;
      randomize_all();
      repeat (3) @(posedge clk);
      // R10: outputs during and just after reset
      @(negedge clk);
      check("R10");
      rst_n = 1'b1;
      n_req = 1'b0;
      cyc("R10");

      // R4: legacy mode, garbage in unused registers, both indices
      for (int i = 0; i < 8; i++) begin
         randomize_all();
         n_leg[12] = 1'b0;
         fire(1'b0, i[0], "R4");
      end

      // R1/R2: contexts zero, one and all ones, distinct bases
      for (int i = 0; i < 12; i++) begin
         randomize_all();
         n_b[0] = 64'h1111_0000_0000_0000; n_b[1] = 64'h2222_0000_0000_0000;
         n_b[2] = 64'h4444_0000_0000_0000; n_b[3] = 64'h8888_0000_0000_0000;
         case (i % 3)
            0: n_tag[12:0] = 13'd0;
            1: n_tag[12:0] = 13'd1;
            default: n_tag[12:0] = 13'h1fff;
         endcase
         fire(1'b1, i[0], (i % 3 == 0) ? "R1" : "R2");
      end

      // R3: differing codes in the two fields, junk elsewhere
      for (int c = 0; c < 8; c++) begin
         randomize_all();
         n_cz = rnd64(); n_cz[2:0] = 3'(c); n_cz[10:8] = 3'(7 - c);
         n_cn = rnd64(); n_cn[2:0] = 3'(7 - c); n_cn[10:8] = 3'(c);
         fire(1'b1, c[0], "R3");
         fire(1'b1, ~c[0], "R3");
      end

      // R5/R6: every code x every size, split off
      for (int c = 0; c < 8; c++) begin
         for (int s = 0; s < 16; s++) begin
            randomize_all();
            n_tag[12:0] = 13'd0;
            n_cz[2:0] = 3'(c); n_cz[10:8] = 3'(c);
            n_b[0][12] = 1'b0; n_b[0][3:0] = 4'(s);
            fire(1'b1, 1'b0, (s % 2 == 0) ? "R5" : "R6");
         end
      end

      // R7: split set, every size, both indices
      for (int s = 0; s < 16; s++) begin
         for (int ix = 0; ix < 2; ix++) begin
            randomize_all();
            n_leg[12] = 1'b1; n_leg[3:0] = 4'(s);
            fire(1'b0, ix[0], "R7");
            n_b[ix + 2][12] = 1'b1; n_b[ix + 2][3:0] = 4'(s);
            n_tag[0] = 1'b1;
            fire(1'b1, ix[0], "R7");
         end
      end

      // R9: idle cycles with changing inputs keep the pointer
      for (int i = 0; i < 6; i++) begin
         randomize_all();
         fire(1'b1, 1'b1, "R9");
         n_req = 1'b0;
         for (int j = 0; j < 3; j++) begin
            randomize_all();
            cyc("R9");
         end
      end

      // R8 and everything else: random traffic (alignment is in every compare)
      for (int i = 0; i < 2000; i++) begin
         randomize_all();
         n_req = ($urandom() % 4) != 0;
         n_hyp = $urandom() % 2;
         n_idx = $urandom() % 2;
         if ($urandom() % 4 == 0) n_tag[12:0] = 13'd0;
         cyc("R8");
      end
      n_req = 1'b0;
      cyc("R9");
      cyc("R9");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule